// File: doc/BRIEF.md
# Shared Coprocessor Auto-Lock Arbiter

This block guards one shared multi-cycle arithmetic unit, such as a multiplier, divider or CORDIC engine, in a core whose instruction slots are time-sliced among hardware tasks. Each cycle the decode stage presents the ID of the issuing task and the class of its access to the unit. There are four classes: setup write, start write, result read with a read index, or no access.

The arbiter decides whether that instruction may execute. When it may not, the stall output tells the pipeline to re-run the instruction on the task's next slot, which is a jump to itself. Ownership is never requested explicitly:

- The first write of either kind to a free unit claims it for the issuing task.
- The owner's read at the designated final index frees the unit again.
- Only tasks other than the owner are held back.

Because tasks may get very uneven shares of the slots, the lock follows access events only. It never follows elapsed clocks. A synchronous clear input force-frees the unit when its owner is killed.

Top module: `colock_arbiter`

## Requirements
- R1: After synchronous reset the unit is free: `lock_busy`=0, `lock_owner`=0, and `stall`=0 while no access is presented.
- R2: A setup write (`req_op`=2'b01) with `req_valid`=1 to a free unit is not stalled. From the next cycle `lock_busy`=1 and `lock_owner` equals the issuing `req_id`.
- R3: A start write (`req_op`=2'b10) to a free unit likewise is not stalled. From the next cycle it makes the issuing task the owner with `lock_busy`=1.
- R4: While busy, any access (setup, start or read of any index) by a task other than the owner raises `stall` in the same cycle. It leaves `lock_busy` and `lock_owner` unchanged.
- R5: The owner is never stalled. Its setup followed by start proceeds without waiting, and ownership stays with it.
- R6: A result read (`req_op`=2'b11) by the owner with `req_rd_idx` equal to parameter FINAL_RD_IDX (default 1, for two result reads) frees the unit from the next cycle: `lock_busy`=0, `lock_owner`=0.
- R7: A result read by the owner at any other index leaves the unit busy and owned.
- R8: A result read of any index while the unit is free is not stalled and leaves the unit free.
- R9: `lock_clr`=1 frees the unit at the next edge. This has priority over an acquiring write in the same cycle.
- R10: A task stalled on a busy unit acquires it with its retry in the cycle after the owner's final read. It is not stalled on that retry.
- R11: Cycles with no access (`req_valid`=0 or `req_op`=2'b00) never change the lock, however many pass between the owner's accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lock_clr | input | 1 | Synchronous force-free of the lock |
| req_valid | input | 1 | An instruction is issuing this cycle |
| req_id | input | TASK_W (2) | ID of the issuing task |
| req_op | input | 2 | Access class: 00 none, 01 setup, 10 start, 11 read |
| req_rd_idx | input | RD_W (1) | Result read index, used only when the access is a read |
| stall | output | 1 | The issuing instruction must re-execute (jump to self) |
| lock_busy | output | 1 | The unit is owned |
| lock_owner | output | TASK_W (2) | ID of the owning task, 0 when free |

## Verification
The arbiter is driven with several access patterns, and each one separates a different way the lock could go wrong:

- **Setup-led and start-led acquisition.** These show that both write kinds claim the unit.
- **Intermediate reads separated by long idle gaps.** These separate a lock held by events from one released by time.
- **Every access class from non-owners during ownership.** This exposes a lock that blocks only writes or that lets a stranger's final read release the unit.
- **A retry right after the release.** This shows whether the waiting task gets the unit on its next slot.
- **Free-unit reads.** These confirm that reads never claim the unit.
- **Clear asserted together with an acquiring write.** This pins down which of the two wins.

// File: rtl/colock_pkg.sv
package colock_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_SETUP = 2'b01,
    OP_START = 2'b10,
    OP_READ  = 2'b11
  } colock_op_e;
endpackage

// File: rtl/colock_classify.sv
module colock_classify
  import colock_pkg::*;
#(
  parameter int RD_W         = 1,
  parameter int FINAL_RD_IDX = 1
) (
  input  logic            valid,
  input  logic [1:0]      op,
  input  logic [RD_W-1:0] rd_idx,
  output logic            acc_any,
  output logic            acc_write,
  output logic            acc_final
);
  colock_op_e op_e;

  always_comb begin
    op_e      = colock_op_e'(op);
    acc_any   = valid && (op_e != OP_NONE);
    acc_write = valid && ((op_e == OP_SETUP) || (op_e == OP_START));
    acc_final = valid && (op_e == OP_READ) && (rd_idx == RD_W'(FINAL_RD_IDX));
  end
endmodule

// File: rtl/colock_gate.sv
module colock_gate #(
  parameter int NUM_TASKS = 4,
  parameter int TASK_W    = 2
) (
  input  logic              busy,
  input  logic [TASK_W-1:0] owner,
  input  logic [TASK_W-1:0] req_id,
  input  logic              acc_any,
  input  logic              acc_write,
  input  logic              acc_final,
  output logic              stall,
  output logic              take,
  output logic              drop
);
  logic [NUM_TASKS-1:0] id_hot;
  logic [NUM_TASKS-1:0] own_hot;
  logic                 is_owner;

  for (genvar i = 0; i < NUM_TASKS; i++) begin : g_slot
    assign id_hot[i]  = (req_id == TASK_W'(i));
    assign own_hot[i] = busy && (owner == TASK_W'(i));
  end

  always_comb begin
    is_owner = |(id_hot & own_hot);
    stall    = acc_any && busy && !is_owner;
    take     = acc_write && !busy;
    drop     = acc_final && is_owner;
  end
endmodule

// File: rtl/colock_state.sv
module colock_state #(
  parameter int TASK_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              take,
  input  logic              drop,
  input  logic [TASK_W-1:0] req_id,
  output logic              busy_q,
  output logic [TASK_W-1:0] owner_q
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      busy_q  <= 1'b0;
      owner_q <= '0;
    end else if (take) begin
      busy_q  <= 1'b1;
      owner_q <= req_id;
    end else if (drop) begin
      busy_q  <= 1'b0;
      owner_q <= '0;
    end
  end
endmodule

// File: rtl/colock_arbiter.sv
module colock_arbiter #(
  parameter int NUM_TASKS    = 4,
  parameter int NUM_READS    = 2,
  parameter int FINAL_RD_IDX = NUM_READS - 1,
  localparam int TASK_W      = (NUM_TASKS > 1) ? $clog2(NUM_TASKS) : 1,
  localparam int RD_W        = (NUM_READS > 1) ? $clog2(NUM_READS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lock_clr,
  input  logic              req_valid,
  input  logic [TASK_W-1:0] req_id,
  input  logic [1:0]        req_op,
  input  logic [RD_W-1:0]   req_rd_idx,
  output logic              stall,
  output logic              lock_busy,
  output logic [TASK_W-1:0] lock_owner
);
  logic acc_any, acc_write, acc_final;
  logic take, drop;

  colock_classify #(.RD_W(RD_W), .FINAL_RD_IDX(FINAL_RD_IDX)) i_classify (
    .valid(req_valid), .op(req_op), .rd_idx(req_rd_idx),
    .acc_any(acc_any), .acc_write(acc_write), .acc_final(acc_final)
  );

  colock_gate #(.NUM_TASKS(NUM_TASKS), .TASK_W(TASK_W)) i_gate (
    .busy(lock_busy), .owner(lock_owner), .req_id(req_id),
    .acc_any(acc_any), .acc_write(acc_write), .acc_final(acc_final),
    .stall(stall), .take(take), .drop(drop)
  );

  colock_state #(.TASK_W(TASK_W)) i_state (
    .clk(clk), .rst(rst), .clr(lock_clr), .take(take), .drop(drop),
    .req_id(req_id), .busy_q(lock_busy), .owner_q(lock_owner)
  );
endmodule

// File: rtl/colock_arbiter_chk.sv
module colock_arbiter_chk #(
  parameter int TASK_W       = 2,
  parameter int RD_W         = 1,
  parameter int FINAL_RD_IDX = 1
) (
  input logic              clk,
  input logic              rst,
  input logic              lock_clr,
  input logic              req_valid,
  input logic [TASK_W-1:0] req_id,
  input logic [1:0]        req_op,
  input logic [RD_W-1:0]   req_rd_idx,
  input logic              stall,
  input logic              lock_busy,
  input logic [TASK_W-1:0] lock_owner
);
  logic is_write, is_any, is_final_rd;
  assign is_write    = req_valid && (req_op == 2'b01 || req_op == 2'b10);
  assign is_any      = req_valid && (req_op != 2'b00);
  assign is_final_rd = req_valid && (req_op == 2'b11) && (req_rd_idx == RD_W'(FINAL_RD_IDX));

  p_reset_free_r1: assert property (@(posedge clk)
    rst |=> (!lock_busy && lock_owner == '0));

  p_acquire_r2: assert property (@(posedge clk) disable iff (rst)
    (!lock_busy && is_write && !lock_clr) |=> (lock_busy && lock_owner == $past(req_id)));

  p_other_stalled_r4: assert property (@(posedge clk) disable iff (rst)
    (lock_busy && is_any && req_id != lock_owner) |-> stall);

  p_stall_keeps_r4: assert property (@(posedge clk) disable iff (rst)
    (stall && !lock_clr) |=> ($stable(lock_busy) && $stable(lock_owner)));

  p_owner_runs_r5: assert property (@(posedge clk) disable iff (rst)
    (lock_busy && req_id == lock_owner) |-> !stall);

  p_release_r6: assert property (@(posedge clk) disable iff (rst)
    (lock_busy && is_final_rd && req_id == lock_owner) |=> !lock_busy);

  p_free_read_r8: assert property (@(posedge clk) disable iff (rst)
    !lock_busy |-> !stall);

  p_clear_r9: assert property (@(posedge clk) disable iff (rst)
    lock_clr |=> (!lock_busy && lock_owner == '0));

  p_idle_r11: assert property (@(posedge clk) disable iff (rst)
    (!is_any && !lock_clr) |=> ($stable(lock_busy) && $stable(lock_owner)));
endmodule

bind colock_arbiter colock_arbiter_chk #(
  .TASK_W(TASK_W), .RD_W(RD_W), .FINAL_RD_IDX(FINAL_RD_IDX)
) i_chk (
  .clk(clk), .rst(rst), .lock_clr(lock_clr), .req_valid(req_valid),
  .req_id(req_id), .req_op(req_op), .req_rd_idx(req_rd_idx),
  .stall(stall), .lock_busy(lock_busy), .lock_owner(lock_owner)
);

// File: tb/test_colock_arbiter.sv
module test_colock_arbiter;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       lock_clr = 1'b0;
  logic       req_valid = 1'b0;
  logic [1:0] req_id = 2'd0;
  logic [1:0] req_op = 2'b00;
  logic [0:0] req_rd_idx = 1'b0;
  logic       stall;
  logic       lock_busy;
  logic [1:0] lock_owner;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  localparam logic [1:0] SETUP = 2'b01, START = 2'b10, READ = 2'b11;

  always #2 clk = ~clk;

  colock_arbiter i_colock_arbiter (
    .clk(clk), .rst(rst), .lock_clr(lock_clr), .req_valid(req_valid),
    .req_id(req_id), .req_op(req_op), .req_rd_idx(req_rd_idx),
    .stall(stall), .lock_busy(lock_busy), .lock_owner(lock_owner)
  );

  task automatic drive(input logic v, input logic [1:0] id, input logic [1:0] op,
                       input logic idx, input logic clr);
    @(negedge clk);
    req_valid = v; req_id = id; req_op = op; req_rd_idx = idx; lock_clr = clr;
    #1;
  endtask

  task automatic idle();
    drive(1'b0, 2'd0, 2'b00, 1'b0, 1'b0);
  endtask

  task automatic edge_step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk_stall(input logic exp, input string tag);
    n_checks++;
    if (stall !== exp) begin
      n_fail++;
      $display("FAIL %s stall actual=%0b expected=%0b", tag, stall, exp);
    end
  endtask

  task automatic chk_state(input logic eb, input logic [1:0] eo, input string tag);
    n_checks++;
    if (lock_busy !== eb || lock_owner !== eo) begin
      n_fail++;
      $display("FAIL %s busy/owner actual=%0b/%0d expected=%0b/%0d",
               tag, lock_busy, lock_owner, eb, eo);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    idle();
    chk_state(1'b0, 2'd0, "R1 reset");
    chk_stall(1'b0, "R1 reset");
  endtask

  task automatic t_setup_flow();
    drive(1'b1, 2'd2, SETUP, 1'b0, 1'b0);
    chk_stall(1'b0, "R2 setup free");
    edge_step();
    chk_state(1'b1, 2'd2, "R2 setup acquires");
    drive(1'b1, 2'd2, START, 1'b0, 1'b0);
    chk_stall(1'b0, "R5 owner start");
    edge_step();
    chk_state(1'b1, 2'd2, "R5 owner kept");
    drive(1'b1, 2'd2, READ, 1'b0, 1'b0);
    chk_stall(1'b0, "R7 owner mid read");
    edge_step();
    chk_state(1'b1, 2'd2, "R7 mid read holds");
    idle();
    repeat (20) @(posedge clk);
    #1;
    chk_state(1'b1, 2'd2, "R11 idle gap holds");
    drive(1'b1, 2'd2, READ, 1'b1, 1'b0);
    chk_stall(1'b0, "R6 owner final");
    edge_step();
    chk_state(1'b0, 2'd0, "R6 final releases");
    idle();
  endtask

  task automatic t_contend();
    drive(1'b1, 2'd1, START, 1'b0, 1'b0);
    chk_stall(1'b0, "R3 start free");
    edge_step();
    chk_state(1'b1, 2'd1, "R3 start acquires");
    drive(1'b1, 2'd3, SETUP, 1'b0, 1'b0);
    chk_stall(1'b1, "R4 other setup");
    edge_step();
    chk_state(1'b1, 2'd1, "R4 setup no effect");
    drive(1'b1, 2'd0, READ, 1'b1, 1'b0);
    chk_stall(1'b1, "R4 other final read");
    edge_step();
    chk_state(1'b1, 2'd1, "R4 stranger no release");
    drive(1'b1, 2'd2, START, 1'b0, 1'b0);
    chk_stall(1'b1, "R4 other start");
    // uneven slots: waiting task retries many times around one owner read
    for (int k = 0; k < 15; k++) begin
      drive(1'b1, 2'd3, SETUP, 1'b0, 1'b0);
    end
    chk_stall(1'b1, "R4 retry still stalled");
    drive(1'b1, 2'd1, READ, 1'b0, 1'b0);
    edge_step();
    chk_state(1'b1, 2'd1, "R7 mid read after gap");
    drive(1'b1, 2'd1, READ, 1'b1, 1'b0);
    edge_step();
    chk_state(1'b0, 2'd0, "R6 owner release");
    drive(1'b1, 2'd3, SETUP, 1'b0, 1'b0);
    chk_stall(1'b0, "R10 retry after release");
    edge_step();
    chk_state(1'b1, 2'd3, "R10 waiter acquires");
    drive(1'b1, 2'd3, READ, 1'b1, 1'b0);
    edge_step();
    idle();
  endtask

  task automatic t_free_read();
    drive(1'b1, 2'd0, READ, 1'b1, 1'b0);
    chk_stall(1'b0, "R8 free final read");
    edge_step();
    chk_state(1'b0, 2'd0, "R8 free read no claim");
    drive(1'b1, 2'd3, READ, 1'b0, 1'b0);
    chk_stall(1'b0, "R8 free mid read");
    edge_step();
    chk_state(1'b0, 2'd0, "R8 free mid no claim");
    idle();
  endtask

  task automatic t_clear();
    drive(1'b1, 2'd0, SETUP, 1'b0, 1'b0);
    edge_step();
    chk_state(1'b1, 2'd0, "R9 pre-clear owned");
    drive(1'b1, 2'd1, SETUP, 1'b0, 1'b1);
    edge_step();
    chk_state(1'b0, 2'd0, "R9 clear frees");
    drive(1'b1, 2'd2, START, 1'b0, 1'b1);
    edge_step();
    chk_state(1'b0, 2'd0, "R9 clear beats acquire");
    idle();
    edge_step();
    chk_state(1'b0, 2'd0, "R11 idle after clear");
  endtask

  initial begin
    t_reset();
    t_setup_flow();
    t_contend();
    t_free_read();
    t_clear();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule